// File: doc/BRIEF.md
# Speculative/Architectural Register Alias Table

This block holds the logical-to-physical register map of an out-of-order core in two copies. The speculative copy is read and updated at rename: each rename lane reads the physical register of each of its sources, plus the current mapping of its destination (the physical register that the new one replaces), and a lane that was granted a new physical register writes it into the speculative copy. The architectural copy is updated only when instructions retire, so it always describes the committed program state.

Recovery uses two mechanisms. During a walk, the commit lanes carry walked-back entries and each one that has a destination restores its old physical register into the speculative copy; rename writes are held off for the whole walk. On a flush the speculative copy is reloaded from the architectural copy in a single cycle. A redirect drops that cycle's rename writes. Integer logical register 0 is pinned to physical register 0, and the whole architectural copy is exposed on a flat debug output.

Top module: `rat_spec_arch`

## Requirements
- R1: After reset, both copies hold the identity map: logical register i maps to physical register i.
- R2: Every read port is combinational and returns the speculative mapping as it stood before the current cycle's writes. Read port j of rename lane k sits at index k*(SRCS+1)+j; the last port of each lane is the destination read that yields the old physical register.
- R3: A rename lane with its write enable set, outside a walk, redirect or flush, writes its new physical register into the speculative copy at its logical destination; the result is visible from the next cycle and the architectural copy is unchanged.
- R4: When several writes to one copy in one cycle target the same logical register, the highest-numbered lane wins.
- R5: A commit lane that is valid, has a destination and is not in a walk writes its committed physical register into the architectural copy at its logical destination; the speculative copy is unaffected by it. With no such lane, or during a walk, the architectural copy holds.
- R6: During a walk, each valid commit lane that has a destination writes its old physical register into the speculative copy at its logical destination.
- R7: While a walk is in progress, rename write enables have no effect on the speculative copy.
- R8: While redirect is high, rename write enables have no effect on the speculative copy.
- R9: On flush, the speculative copy becomes equal to the architectural copy including any retirement writes of that same cycle; flush overrides all other speculative writes.
- R10: Writes to logical register 0 are ignored in both copies (integer configuration), so it always reads as physical register 0.
- R11: The debug output carries the architectural copy with logical register i at bits [i*PW +: PW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Reload speculative copy from architectural copy |
| redirect_i | input | 1 | Drop this cycle's rename writes |
| walk_i | input | 1 | Commit lanes carry walk entries |
| ren_wen_i | input | REN_LANES | Rename lane granted a new physical register |
| ren_ldst_i | input | REN_LANES*LW | Logical destination per rename lane |
| ren_pdst_i | input | REN_LANES*PW | New physical register per rename lane |
| rd_lreg_i | input | REN_LANES*(SRCS+1)*LW | Read port addresses |
| rd_preg_o | output | REN_LANES*(SRCS+1)*PW | Read port data |
| cm_valid_i | input | CM_LANES | Commit/walk lane valid |
| cm_hasdst_i | input | CM_LANES | Entry writes a destination |
| cm_ldst_i | input | CM_LANES*LW | Logical destination per lane |
| cm_pdst_i | input | CM_LANES*PW | Committed physical register |
| cm_oldp_i | input | CM_LANES*PW | Old physical register restored on walk |
| arch_map_o | output | NUM_LREG*PW | Full architectural map |

## Verification
The bench sweeps every logical register through rename writes and reads the whole speculative copy back through the read ports, so a wrong decoder or a read that shows the new value too early (breaking R2) shows up on a specific entry. Same-register collisions among rename lanes and among walk lanes catch a priority chain running the wrong way, which would keep the lowest lane's value. Rename enables asserted together with walk or redirect catch a missing suppression, which would leave the rename value in the map. A flush issued in the same cycle as retirement writes catches a design that copies the stale architectural copy, and writes to register 0 catch a design that lets it drift from 0.

// File: rtl/rat_pkg.sv
`timescale 1ns/1ps
package rat_pkg;

  // Source that drives a speculative write port in a given cycle.
  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_REN  = 2'd1,
    WSRC_WALK = 2'd2
  } wsrc_e;

  function automatic int unsigned clog2u(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/rat_wport_sel.sv
`timescale 1ns/1ps
module rat_wport_sel
  import rat_pkg::*;
#(
  parameter int unsigned REN_LANES = 2,
  parameter int unsigned CM_LANES  = 3,
  parameter int unsigned LW        = 5,
  parameter int unsigned PW        = 6,
  parameter bit          ZERO_PIN  = 1'b1
) (
  input  logic                   walk_i,
  input  logic                   redirect_i,
  input  logic [REN_LANES-1:0]   ren_wen_i,
  input  logic [REN_LANES*LW-1:0] ren_ldst_i,
  input  logic [REN_LANES*PW-1:0] ren_pdst_i,
  input  logic [CM_LANES-1:0]    cm_valid_i,
  input  logic [CM_LANES-1:0]    cm_hasdst_i,
  input  logic [CM_LANES*LW-1:0] cm_ldst_i,
  input  logic [CM_LANES*PW-1:0] cm_pdst_i,
  input  logic [CM_LANES*PW-1:0] cm_oldp_i,
  output logic [CM_LANES-1:0]    spec_we_o,
  output logic [CM_LANES*LW-1:0] spec_wa_o,
  output logic [CM_LANES*PW-1:0] spec_wd_o,
  output logic [CM_LANES-1:0]    arch_we_o,
  output logic [CM_LANES*LW-1:0] arch_wa_o,
  output logic [CM_LANES*PW-1:0] arch_wd_o
);

  for (genvar i = 0; i < CM_LANES; i++) begin : g_port
    logic [LW-1:0] c_ldst;
    logic          c_nz;
    logic          c_act;
    wsrc_e         src;

    assign c_ldst = cm_ldst_i[i*LW +: LW];
    assign c_nz   = (ZERO_PIN == 1'b0) || (c_ldst != '0);
    assign c_act  = cm_valid_i[i] & cm_hasdst_i[i] & c_nz;

    // Retirement path into the architectural copy.
    assign arch_we_o[i]            = c_act & ~walk_i;
    assign arch_wa_o[i*LW +: LW]   = c_ldst;
    assign arch_wd_o[i*PW +: PW]   = cm_pdst_i[i*PW +: PW];

    if (i < REN_LANES) begin : g_shared
      logic [LW-1:0] r_ldst;
      logic          r_act;
      assign r_ldst = ren_ldst_i[i*LW +: LW];
      assign r_act  = ren_wen_i[i] & ~redirect_i &
                      ((ZERO_PIN == 1'b0) || (r_ldst != '0));

      always_comb begin
        if (walk_i)     src = c_act ? WSRC_WALK : WSRC_NONE;
        else if (r_act) src = WSRC_REN;
        else            src = WSRC_NONE;
      end

      always_comb begin
        unique case (src)
          WSRC_WALK: begin
            spec_we_o[i]          = 1'b1;
            spec_wa_o[i*LW +: LW] = c_ldst;
            spec_wd_o[i*PW +: PW] = cm_oldp_i[i*PW +: PW];
          end
          WSRC_REN: begin
            spec_we_o[i]          = 1'b1;
            spec_wa_o[i*LW +: LW] = r_ldst;
            spec_wd_o[i*PW +: PW] = ren_pdst_i[i*PW +: PW];
          end
          default: begin
            spec_we_o[i]          = 1'b0;
            spec_wa_o[i*LW +: LW] = r_ldst;
            spec_wd_o[i*PW +: PW] = ren_pdst_i[i*PW +: PW];
          end
        endcase
      end
    end else begin : g_walk_only
      assign src                   = (walk_i & c_act) ? WSRC_WALK : WSRC_NONE;
      assign spec_we_o[i]          = (src == WSRC_WALK);
      assign spec_wa_o[i*LW +: LW] = c_ldst;
      assign spec_wd_o[i*PW +: PW] = cm_oldp_i[i*PW +: PW];
    end
  end

endmodule

// File: rtl/rat_map_bank.sv
`timescale 1ns/1ps
module rat_map_bank #(
  parameter int unsigned NWP = 3,
  parameter int unsigned NL  = 32,
  parameter int unsigned LW  = 5,
  parameter int unsigned PW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWP-1:0]    we_i,
  input  logic [NWP*LW-1:0] wa_i,
  input  logic [NWP*PW-1:0] wd_i,
  input  logic              load_i,
  input  logic [NL*PW-1:0]  load_map_i,
  output logic [NL*PW-1:0]  map_o,
  output logic [NL*PW-1:0]  map_nxt_o
);

  logic [PW-1:0] map_q [NL];
  logic [PW-1:0] map_d [NL];
  logic          upd_en;

  assign upd_en = load_i | (|we_i);

  // Next state: a full load wins; otherwise ports apply in ascending
  // order so the highest-numbered port wins on a shared address.
  always_comb begin
    for (int e = 0; e < NL; e++) map_d[e] = map_q[e];
    if (load_i) begin
      for (int e = 0; e < NL; e++) map_d[e] = load_map_i[e*PW +: PW];
    end else begin
      for (int p = 0; p < NWP; p++) begin
        if (we_i[p]) map_d[wa_i[p*LW +: LW]] = wd_i[p*PW +: PW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NL; e++) map_q[e] <= PW'(e);
    end else if (upd_en) begin
      for (int e = 0; e < NL; e++) map_q[e] <= map_d[e];
    end
  end

  for (genvar e = 0; e < NL; e++) begin : g_flat
    assign map_o[e*PW +: PW]     = map_q[e];
    assign map_nxt_o[e*PW +: PW] = map_d[e];
  end

endmodule

// File: rtl/rat_read_xbar.sv
`timescale 1ns/1ps
module rat_read_xbar #(
  parameter int unsigned NR = 6,
  parameter int unsigned NL = 32,
  parameter int unsigned LW = 5,
  parameter int unsigned PW = 6
) (
  input  logic [NL*PW-1:0] map_i,
  input  logic [NR*LW-1:0] addr_i,
  output logic [NR*PW-1:0] data_o
);

  for (genvar r = 0; r < NR; r++) begin : g_rd
    logic [LW-1:0] a;
    assign a                  = addr_i[r*LW +: LW];
    assign data_o[r*PW +: PW] = map_i[a*PW +: PW];
  end

endmodule

// File: rtl/rat_spec_arch.sv
`timescale 1ns/1ps
module rat_spec_arch
  import rat_pkg::*;
#(
  parameter int unsigned NUM_LREG  = 32,
  parameter int unsigned NUM_PREG  = 64,
  parameter int unsigned REN_LANES = 2,
  parameter int unsigned SRCS      = 2,
  parameter int unsigned CM_LANES  = 3,
  parameter bit          ZERO_PIN  = 1'b1,
  localparam int unsigned LW       = clog2u(NUM_LREG),
  localparam int unsigned PW       = clog2u(NUM_PREG),
  localparam int unsigned NRD      = REN_LANES * (SRCS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush_i,
  input  logic                    redirect_i,
  input  logic                    walk_i,
  input  logic [REN_LANES-1:0]    ren_wen_i,
  input  logic [REN_LANES*LW-1:0] ren_ldst_i,
  input  logic [REN_LANES*PW-1:0] ren_pdst_i,
  input  logic [NRD*LW-1:0]       rd_lreg_i,
  output logic [NRD*PW-1:0]       rd_preg_o,
  input  logic [CM_LANES-1:0]     cm_valid_i,
  input  logic [CM_LANES-1:0]     cm_hasdst_i,
  input  logic [CM_LANES*LW-1:0]  cm_ldst_i,
  input  logic [CM_LANES*PW-1:0]  cm_pdst_i,
  input  logic [CM_LANES*PW-1:0]  cm_oldp_i,
  output logic [NUM_LREG*PW-1:0]  arch_map_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic [CM_LANES-1:0]    spec_we, arch_we;
  logic [CM_LANES*LW-1:0] spec_wa, arch_wa;
  logic [CM_LANES*PW-1:0] spec_wd, arch_wd;
  logic [NUM_LREG*PW-1:0] spec_map, spec_nxt, arch_nxt;

  rat_wport_sel #(
    .REN_LANES(REN_LANES), .CM_LANES(CM_LANES),
    .LW(LW), .PW(PW), .ZERO_PIN(ZERO_PIN)
  ) u_wsel (
    .walk_i      (walk_i),
    .redirect_i  (redirect_i),
    .ren_wen_i   (ren_wen_i),
    .ren_ldst_i  (ren_ldst_i),
    .ren_pdst_i  (ren_pdst_i),
    .cm_valid_i  (cm_valid_i),
    .cm_hasdst_i (cm_hasdst_i),
    .cm_ldst_i   (cm_ldst_i),
    .cm_pdst_i   (cm_pdst_i),
    .cm_oldp_i   (cm_oldp_i),
    .spec_we_o   (spec_we),
    .spec_wa_o   (spec_wa),
    .spec_wd_o   (spec_wd),
    .arch_we_o   (arch_we),
    .arch_wa_o   (arch_wa),
    .arch_wd_o   (arch_wd)
  );

  rat_map_bank #(.NWP(CM_LANES), .NL(NUM_LREG), .LW(LW), .PW(PW)) u_arch (
    .clk        (clk),
    .rst_n      (rst_ok),
    .we_i       (arch_we),
    .wa_i       (arch_wa),
    .wd_i       (arch_wd),
    .load_i     (1'b0),
    .load_map_i ('0),
    .map_o      (arch_map_o),
    .map_nxt_o  (arch_nxt)
  );

  // Flush reloads from the architectural copy as updated this cycle.
  rat_map_bank #(.NWP(CM_LANES), .NL(NUM_LREG), .LW(LW), .PW(PW)) u_spec (
    .clk        (clk),
    .rst_n      (rst_ok),
    .we_i       (spec_we),
    .wa_i       (spec_wa),
    .wd_i       (spec_wd),
    .load_i     (flush_i),
    .load_map_i (arch_nxt),
    .map_o      (spec_map),
    .map_nxt_o  (spec_nxt)
  );

  rat_read_xbar #(.NR(NRD), .NL(NUM_LREG), .LW(LW), .PW(PW)) u_rd (
    .map_i  (spec_map),
    .addr_i (rd_lreg_i),
    .data_o (rd_preg_o)
  );

endmodule

// File: rtl/rat_checker.sv
`timescale 1ns/1ps
module rat_checker #(
  parameter int unsigned NL       = 32,
  parameter int unsigned PW       = 6,
  parameter int unsigned CM_LANES = 3,
  parameter bit          ZERO_PIN = 1'b1
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              flush_i,
  input logic              redirect_i,
  input logic              walk_i,
  input logic [CM_LANES-1:0] cm_valid_i,
  input logic [NL*PW-1:0]  spec_map,
  input logic [NL*PW-1:0]  spec_nxt,
  input logic [NL*PW-1:0]  arch_nxt,
  input logic [NL*PW-1:0]  arch_map_o
);

  a_r10_zero_pinned: assert property (@(posedge clk) disable iff (!rst_ok)
    (ZERO_PIN == 1'b1) |-> (arch_map_o[PW-1:0] == '0 && spec_map[PW-1:0] == '0));

  a_r9_flush_copy: assert property (@(posedge clk) disable iff (!rst_ok)
    flush_i |=> (spec_map == $past(arch_nxt)));

  a_r7_walk_blocks_rename: assert property (@(posedge clk) disable iff (!rst_ok)
    (walk_i && !flush_i && cm_valid_i == '0) |-> (spec_nxt == spec_map));

  a_r8_redirect_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    (redirect_i && !walk_i && !flush_i) |=> $stable(spec_map));

  a_r5_arch_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    (walk_i || cm_valid_i == '0) |=> $stable(arch_map_o));

endmodule

bind rat_spec_arch rat_checker #(
  .NL(NUM_LREG), .PW(PW), .CM_LANES(CM_LANES), .ZERO_PIN(ZERO_PIN)
) u_rat_checker (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .flush_i    (flush_i),
  .redirect_i (redirect_i),
  .walk_i     (walk_i),
  .cm_valid_i (cm_valid_i),
  .spec_map   (spec_map),
  .spec_nxt   (spec_nxt),
  .arch_nxt   (arch_nxt),
  .arch_map_o (arch_map_o)
);

// File: tb/tb_rat_spec_arch.sv
`timescale 1ns/1ps
module tb_rat_spec_arch;
  localparam int NL = 32, LW = 5, PW = 6, RL = 2, S = 2, CL = 3;
  localparam int NR = RL * (S + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic flush, redirect, walk;
  logic [RL-1:0]    ren_wen;
  logic [RL*LW-1:0] ren_ldst;
  logic [RL*PW-1:0] ren_pdst;
  logic [NR*LW-1:0] rd_lreg;
  logic [NR*PW-1:0] rd_preg;
  logic [CL-1:0]    cm_valid, cm_hasdst;
  logic [CL*LW-1:0] cm_ldst;
  logic [CL*PW-1:0] cm_pdst, cm_oldp;
  logic [NL*PW-1:0] arch_map;

  int n_tests = 0;
  int n_fail  = 0;
  logic [PW-1:0] m_spec [NL];
  logic [PW-1:0] m_arch [NL];

  always #10 clk = ~clk;

  rat_spec_arch dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .redirect_i(redirect),
    .walk_i(walk), .ren_wen_i(ren_wen), .ren_ldst_i(ren_ldst),
    .ren_pdst_i(ren_pdst), .rd_lreg_i(rd_lreg), .rd_preg_o(rd_preg),
    .cm_valid_i(cm_valid), .cm_hasdst_i(cm_hasdst), .cm_ldst_i(cm_ldst),
    .cm_pdst_i(cm_pdst), .cm_oldp_i(cm_oldp), .arch_map_o(arch_map)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; redirect = 0; walk = 0;
    ren_wen = '0; ren_ldst = '0; ren_pdst = '0;
    cm_valid = '0; cm_hasdst = '0; cm_ldst = '0; cm_pdst = '0; cm_oldp = '0;
  endtask

  task automatic ren(input int k, input int l, input int p);
    ren_wen[k] = 1'b1; ren_ldst[k*LW +: LW] = LW'(l); ren_pdst[k*PW +: PW] = PW'(p);
  endtask

  task automatic cm(input int i, input int l, input int p, input int o);
    cm_valid[i] = 1'b1; cm_hasdst[i] = 1'b1;
    cm_ldst[i*LW +: LW] = LW'(l); cm_pdst[i*PW +: PW] = PW'(p);
    cm_oldp[i*PW +: PW] = PW'(o);
  endtask

  // Model update from the requirements, then one clock edge.
  task automatic cycle();
    logic [PW-1:0] na [NL];
    logic [PW-1:0] ns [NL];
    for (int e = 0; e < NL; e++) begin na[e] = m_arch[e]; ns[e] = m_spec[e]; end
    for (int i = 0; i < CL; i++)
      if (!walk && cm_valid[i] && cm_hasdst[i] && cm_ldst[i*LW +: LW] != 0)
        na[cm_ldst[i*LW +: LW]] = cm_pdst[i*PW +: PW];
    if (flush) begin
      for (int e = 0; e < NL; e++) ns[e] = na[e];
    end else if (walk) begin
      for (int i = 0; i < CL; i++)
        if (cm_valid[i] && cm_hasdst[i] && cm_ldst[i*LW +: LW] != 0)
          ns[cm_ldst[i*LW +: LW]] = cm_oldp[i*PW +: PW];
    end else if (!redirect) begin
      for (int k = 0; k < RL; k++)
        if (ren_wen[k] && ren_ldst[k*LW +: LW] != 0)
          ns[ren_ldst[k*LW +: LW]] = ren_pdst[k*PW +: PW];
    end
    @(posedge clk);
    for (int e = 0; e < NL; e++) begin m_arch[e] = na[e]; m_spec[e] = ns[e]; end
    #2;
  endtask

  task automatic check_spec(input string req);
    for (int g = 0; g < NL; g += NR) begin
      for (int r = 0; r < NR; r++) rd_lreg[r*LW +: LW] = LW'((g + r) % NL);
      #1;
      for (int r = 0; r < NR; r++)
        chk(req, int'(rd_preg[r*PW +: PW]), int'(m_spec[(g + r) % NL]));
    end
  endtask

  task automatic check_arch(input string req);
    for (int e = 0; e < NL; e++)
      chk(req, int'(arch_map[e*PW +: PW]), int'(m_arch[e]));
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(); rd_lreg = '0; rst_n = 0;
    for (int e = 0; e < NL; e++) begin m_spec[e] = PW'(e); m_arch[e] = PW'(e); end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    // R1 / R11: identity after reset, arch map on debug bus
    check_spec("R1");
    check_arch("R11");

    // R3 sweep with R2 same-cycle read of old mapping (port 2 = lane0 dest read)
    for (int l = 0; l < NL; l++) begin
      idle(); ren(0, l, (l + 32) % 64);
      rd_lreg[2*LW +: LW] = LW'(l); #1;
      chk("R2", int'(rd_preg[2*PW +: PW]), int'(m_spec[l]));
      cycle();
    end
    idle(); check_spec("R3"); check_arch("R3");
    chk("R10", int'(m_spec[0]), 0);

    // R4: both rename lanes hit the same register
    idle(); ren(0, 5, 40); ren(1, 5, 41); cycle();
    idle(); rd_lreg[5*LW +: LW] = 5'd5; #1;
    chk("R4", int'(rd_preg[5*PW +: PW]), 41);

    // R10: register 0 ignored in both copies
    idle(); ren(1, 0, 17); cm(0, 0, 18, 19); cycle();
    idle(); rd_lreg[0 +: LW] = '0; #1;
    chk("R10", int'(rd_preg[0 +: PW]), 0);
    chk("R10", int'(arch_map[0 +: PW]), 0);

    // R5: retirement sweep, all lanes, with a lane collision
    for (int l = 1; l < NL; l += 3) begin
      idle(); cm(0, l, 50, 1); cm(1, (l + 1) % NL, 51, 2); cm(2, l, 52, 3); cycle();
      idle(); check_arch("R5");
    end
    chk("R5", int'(arch_map[1*PW +: PW]), 52);
    // valid without destination does nothing
    idle(); cm_valid = '1; cm_hasdst = '0; cm_ldst = '1; cycle();
    idle(); check_arch("R5"); check_spec("R5");

    // R6 / R7: walk with rename asserted; lanes 0 and 2 collide
    idle(); walk = 1; ren(0, 9, 60); ren(1, 10, 61);
    cm(0, 12, 7, 33); cm(1, 13, 7, 34); cm(2, 12, 7, 35); cycle();
    idle(); check_spec("R6"); check_arch("R6");
    rd_lreg[0 +: LW] = 5'd12; rd_lreg[LW +: LW] = 5'd9; #1;
    chk("R6", int'(rd_preg[0 +: PW]), 35);
    chk("R7", int'(rd_preg[PW +: PW]), int'(m_spec[9]));

    // R8: redirect drops renames
    idle(); redirect = 1; ren(0, 20, 1); ren(1, 21, 2); cycle();
    idle(); check_spec("R8");

    // R9: flush with same-cycle retirement and rename
    idle(); flush = 1; ren(0, 3, 62); cm(1, 4, 44, 0); cycle();
    idle(); check_spec("R9"); check_arch("R9");
    rd_lreg[0 +: LW] = 5'd4; #1;
    chk("R9", int'(rd_preg[0 +: PW]), 44);

    // Mixed random traffic against the model
    for (int c = 0; c < 400; c++) begin
      idle();
      walk     = ($urandom % 4) == 0;
      flush    = ($urandom % 16) == 0;
      redirect = ($urandom % 8) == 0;
      for (int k = 0; k < RL; k++)
        if ($urandom % 2) ren(k, $urandom % NL, $urandom % 64);
      for (int i = 0; i < CL; i++)
        if ($urandom % 2) begin
          cm(i, $urandom % NL, $urandom % 64, $urandom % 64);
          cm_hasdst[i] = ($urandom % 4) != 0;
        end
      cycle();
      idle(); check_arch("R5");
      if (c % 10 == 0) check_spec("R9");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule